// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block is a passive observer on the command bus of a two-bank SDRAM. Each clock it decodes the chip-select, row-strobe, column-strobe and write-enable pins, together with the bank select and address bit 9, into a command code. It keeps a state for each bank: idle, refreshing, or mode-register access. It judges every command against the state of the bank that the command concerns, or against all banks for commands that affect the whole device. It never drives the memory. A command that is not allowed produces a one-cycle flag on the following clock.

Refresh and mode-register programming move every bank into a busy state together. A per-bank down-counter returns each bank to idle after a fixed recovery time: a parameter for refresh and two cycles for a mode-register write. A separate timer per bank tracks how recently that bank was activated, so that an activate to a different bank that arrives too soon is caught. The monitor also reports the auto-precharge marker that address bit 9 carries on reads and writes.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: After a synchronous active-low reset, every bank reads idle (state code 0), `illegal` is 0, `cmd_code` is 3'b111 and `auto_pre` is 0.
- R2: One cycle after a sampled edge, `cmd_code` equals {ras_n, cas_n, we_n}. The codes are 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop and 111 no-op. A cycle with `cs_n` high reads as 111 and is never flagged.
- R3: `illegal` is registered. It is high for exactly the one cycle after each offending command and low after an accepted one.
- R4: Mode set and refresh are accepted only when every bank is idle; otherwise they are flagged. An accepted mode set moves all banks to state 2, and an accepted refresh moves all banks to state 1.
- R5: While a bank is refreshing, only burst stop and no-op are accepted. Every other command is flagged.
- R6: After an accepted refresh, the banks read state 1 for TRC-1 cycles and then read idle. The command issued TRC cycles after the refresh is therefore judged in idle.
- R7: After a mode set, only no-op is accepted in the next cycle; burst stop is flagged. The banks read idle again two cycles after the mode set.
- R8: Precharge, activate, read and write are judged against the bank that `bank_sel` names, and are flagged if that bank is not idle.
- R9: An activate is flagged if a different bank had an accepted activate fewer than TRRD cycles earlier.
- R10: One cycle after a read or write with `addr9` high, `auto_pre` is 1; for any other command it is 0.
- R11: A flagged command leaves the bank states and the recovery timers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the observed command bus |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BANK_W | Bank addressed by the command |
| addr9 | input | 1 | Address bit 9 (auto-precharge marker on read/write) |
| bank_state | output | 2*BANKS | Per-bank state, 2 bits per bank, bank 0 in the low bits: 0 idle, 1 refreshing, 2 mode access |
| illegal | output | 1 | One-cycle pulse, one cycle after a disallowed command |
| cmd_code | output | 3 | Registered decoded command |
| auto_pre | output | 1 | Registered auto-precharge marker |

## Verification
The hardest situation to reach from the ports is the exact last cycle of a recovery or spacing window. Examples are a command landing on cycle TRC-1 against cycle TRC after a refresh, and a second activate issued exactly TRRD-1 cycles against TRRD cycles after the first. Random commands rarely line up with these edges. Directed sequences therefore place a refresh and walk it cycle by cycle to its exit. They also place activate pairs at distances one and two, and they try a flagged command inside each busy window to show that state and timers are left alone. Constrained random traffic weighted towards no-op then lets refreshes and mode sets expire naturally between other commands.

// File: rtl/sdram_mon_pkg.sv
// Package: shared command and bank-state encodings for the SDRAM command
// legality monitor. Assumes the active-low pin pattern {ras,cas,we}
// maps directly onto the command code.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_MODE_SET = 3'b000,
        CMD_REFRESH  = 3'b001,
        CMD_PRECHG   = 3'b010,
        CMD_ACTIVATE = 3'b011,
        CMD_WRITE    = 3'b100,
        CMD_READ     = 3'b101,
        CMD_BSTOP    = 3'b110,
        CMD_NOP      = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_REFR = 2'd1,
        BK_MODE = 2'd2
    } bank_st_e;

    // Commands that address one bank through the bank select input
    function automatic logic is_bank_cmd(input cmd_e op);
        return (op == CMD_PRECHG) || (op == CMD_ACTIVATE) ||
               (op == CMD_WRITE)  || (op == CMD_READ);
    endfunction

    // Commands that carry a column address (auto-precharge marker valid)
    function automatic logic is_column_cmd(input cmd_e op);
        return (op == CMD_WRITE) || (op == CMD_READ);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: combinational decoder of the command pins.
// Does: turns chip select and the three strobes into a command code and
// extracts the auto-precharge request for column commands.
// Assumes: inputs are already synchronous to the monitor clock.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic addr9,
    output cmd_e op,
    output logic ap_req,
    output logic bank_cmd
);

    // Deselected cycles read as no-op, selected ones as the pin pattern
    always_comb begin
        if (cs_n) begin
            op = CMD_NOP;
        end else begin
            op = cmd_e'({ras_n, cas_n, we_n});
        end
    end

    // Auto-precharge marker is meaningful only on reads and writes
    always_comb begin
        ap_req = is_column_cmd(op) && addr9;
    end

    // Flag commands that are judged against a single addressed bank
    always_comb begin
        bank_cmd = is_bank_cmd(op);
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
// Module: state and recovery counter of one bank.
// Does: enters refresh or mode-access state on an accepted global
// command, counts down the recovery time and returns to idle.
// Assumes: go_refresh and go_mode are never asserted together, and are
// asserted only while this bank is idle (the legality judge ensures it).
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int TRC   = 7,
    parameter int TMRD  = 2,
    parameter int CNT_W = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_refresh,
    input  logic     go_mode,
    output bank_st_e state
);

    localparam logic [CNT_W-1:0] REF_LOAD  = CNT_W'(TRC - 1);
    localparam logic [CNT_W-1:0] MODE_LOAD = CNT_W'(TMRD - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    // Enter a busy state on request, count it down, then drop back to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= BK_IDLE;
            remain <= '0;
        end else if (go_refresh) begin
            state  <= BK_REFR;
            remain <= REF_LOAD;
        end else if (go_mode) begin
            state  <= BK_MODE;
            remain <= MODE_LOAD;
        end else if (state != BK_IDLE) begin
            if (remain <= ONE) begin
                state  <= BK_IDLE;
                remain <= '0;
            end else begin
                remain <= remain - ONE;
            end
        end
    end

endmodule

// File: rtl/sdram_act_spacing.sv
// Module: per-bank activate spacing timers.
// Does: after an accepted activate to a bank, holds that bank's window
// open for TRRD-1 further cycles; an activate to any other bank in that
// window is too early.
// Assumes: act_fire pulses only for accepted activates.
module sdram_act_spacing #(
    parameter int BANKS  = 2,
    parameter int BANK_W = 1,
    parameter int TRRD   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_fire,
    input  logic [BANK_W-1:0] act_bank,
    output logic [BANKS-1:0]  window_open
);

    localparam int RRD_W = (TRRD > 1) ? $clog2(TRRD) : 1;

    genvar b;
    generate
        if (TRRD > 1) begin : g_timed
            localparam logic [RRD_W-1:0] LOAD = RRD_W'(TRRD - 1);
            for (b = 0; b < BANKS; b++) begin : g_bank
                logic [RRD_W-1:0] cnt;
                // Reload on an activate to this bank, otherwise run down to zero
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cnt <= '0;
                    end else if (act_fire && (act_bank == BANK_W'(b))) begin
                        cnt <= LOAD;
                    end else if (cnt != '0) begin
                        cnt <= cnt - RRD_W'(1);
                    end
                end
                assign window_open[b] = (cnt != '0);
            end
        end else begin : g_untimed
            // A spacing of one cycle or less never blocks an activate
            assign window_open = '0;
        end
    endgenerate

endmodule

// File: rtl/sdram_legality.sv
// Module: combinational legality judge.
// Does: decides whether the decoded command is allowed given every
// bank's state and the activate spacing windows, and produces the
// accepted-command strobes that advance the trackers.
// Assumes: bank_state packs 2 bits per bank, bank 0 in the low bits.
module sdram_legality
    import sdram_mon_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int BANK_W = 1
) (
    input  cmd_e                op,
    input  logic                bank_cmd,
    input  logic [BANK_W-1:0]   bank_sel,
    input  logic [2*BANKS-1:0]  bank_state,
    input  logic [BANKS-1:0]    window_open,
    output logic                bad,
    output logic                go_refresh,
    output logic                go_mode,
    output logic                act_fire
);

    logic     all_idle;
    logic     any_mode;
    logic     other_window;
    bank_st_e target_st;

    // Summaries across all banks: everyone idle, anyone in mode access
    always_comb begin
        all_idle = 1'b1;
        any_mode = 1'b0;
        for (int i = 0; i < BANKS; i++) begin
            if (bank_state[2*i +: 2] != BK_IDLE) all_idle = 1'b0;
            if (bank_state[2*i +: 2] == BK_MODE) any_mode = 1'b1;
        end
    end

    // State of the addressed bank and spacing windows of the other banks
    always_comb begin
        target_st    = BK_IDLE;
        other_window = 1'b0;
        for (int i = 0; i < BANKS; i++) begin
            if (bank_sel == BANK_W'(i)) begin
                target_st = bank_st_e'(bank_state[2*i +: 2]);
            end else if (window_open[i]) begin
                other_window = 1'b1;
            end
        end
    end

    // Verdict for the current command
    always_comb begin
        bad = 1'b0;
        unique case (op)
            CMD_MODE_SET, CMD_REFRESH: bad = !all_idle;
            CMD_BSTOP:                 bad = any_mode;
            CMD_NOP:                   bad = 1'b0;
            default: begin
                if (bank_cmd && (target_st != BK_IDLE)) bad = 1'b1;
                if ((op == CMD_ACTIVATE) && other_window) bad = 1'b1;
            end
        endcase
    end

    // Strobes for accepted commands that change state or timers
    always_comb begin
        go_refresh = (op == CMD_REFRESH)  && !bad;
        go_mode    = (op == CMD_MODE_SET) && !bad;
        act_fire   = (op == CMD_ACTIVATE) && !bad;
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
// Module: top of the SDRAM command legality monitor.
// Does: decodes the command bus, judges each command, keeps per-bank
// state, and registers the illegal pulse, command code and auto-precharge
// marker one cycle after the sampled command.
// Assumes: a passive tap on the bus; TRC >= 2 and TRRD >= 1.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BANKS  = 2,
    parameter int TRC    = 7,
    parameter int TRRD   = 2,
    parameter int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic                 addr9,
    output logic [2*BANKS-1:0]   bank_state,
    output logic                 illegal,
    output logic [2:0]           cmd_code,
    output logic                 auto_pre
);

    localparam int TMRD  = 2;
    localparam int MAXD  = (TRC > TMRD) ? TRC : TMRD;
    localparam int CNT_W = $clog2(MAXD + 1);

    cmd_e             op;
    logic             ap_req;
    logic             bank_cmd;
    logic             bad;
    logic             go_refresh;
    logic             go_mode;
    logic             act_fire;
    logic [BANKS-1:0] window_open;

    sdram_cmd_decode u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr9    (addr9),
        .op       (op),
        .ap_req   (ap_req),
        .bank_cmd (bank_cmd)
    );

    sdram_legality #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W)
    ) u_judge (
        .op          (op),
        .bank_cmd    (bank_cmd),
        .bank_sel    (bank_sel),
        .bank_state  (bank_state),
        .window_open (window_open),
        .bad         (bad),
        .go_refresh  (go_refresh),
        .go_mode     (go_mode),
        .act_fire    (act_fire)
    );

    sdram_act_spacing #(
        .BANKS  (BANKS),
        .BANK_W (BANK_W),
        .TRRD   (TRRD)
    ) u_spacing (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_fire    (act_fire),
        .act_bank    (bank_sel),
        .window_open (window_open)
    );

    genvar b;
    generate
        for (b = 0; b < BANKS; b++) begin : g_bank
            bank_st_e st;
            sdram_bank_tracker #(
                .TRC   (TRC),
                .TMRD  (TMRD),
                .CNT_W (CNT_W)
            ) u_track (
                .clk        (clk),
                .rst_n      (rst_n),
                .go_refresh (go_refresh),
                .go_mode    (go_mode),
                .state      (st)
            );
            assign bank_state[2*b +: 2] = st;
        end
    endgenerate

    // Register the verdict and the decoded view of the sampled command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal  <= 1'b0;
            cmd_code <= CMD_NOP;
            auto_pre <= 1'b0;
        end else begin
            illegal  <= bad;
            cmd_code <= op;
            auto_pre <= ap_req;
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
// Module: assertion checker bound to the monitor top.
// Does: checks port-level timing relations between the command pins
// and the registered outputs. Assumes the 2-bit state code per bank.
module sdram_cmd_monitor_chk #(
    parameter int BANKS  = 2,
    parameter int BANK_W = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic [BANK_W-1:0]   bank_sel,
    input logic                addr9,
    input logic [2*BANKS-1:0]  bank_state,
    input logic                illegal,
    input logic [2:0]          cmd_code,
    input logic                auto_pre
);

    logic all_idle_now;
    always_comb begin
        all_idle_now = (bank_state == '0);
    end

    // R2
    deselect_is_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_code == 3'b111) && !illegal);

    // R2
    pins_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> (cmd_code == $past({ras_n, cas_n, we_n})));

    // R4
    mode_set_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && {ras_n, cas_n, we_n} == 3'b000 && all_idle_now)
        |=> (bank_state[1:0] == 2'd2) && !illegal);

    // R4
    refresh_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && {ras_n, cas_n, we_n} == 3'b001 && all_idle_now)
        |=> (bank_state[1:0] == 2'd1) && !illegal);

    // R7
    mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_state[1:0] == 2'd2) |=> (bank_state[1:0] == 2'd0));

    // R5
    refresh_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_state[1:0] == 2'd1 && !cs_n && !ras_n) |=> illegal);

    // R10
    auto_pre_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> (cmd_code == 3'b100 || cmd_code == 3'b101));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .bank_sel   (bank_sel),
    .addr9      (addr9),
    .bank_state (bank_state),
    .illegal    (illegal),
    .cmd_code   (cmd_code),
    .auto_pre   (auto_pre)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

    localparam int TRC  = 7;
    localparam int TRRD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       ras_n = 1'b1;
    logic       cas_n = 1'b1;
    logic       we_n = 1'b1;
    logic [0:0] bank_sel = 1'b0;
    logic       addr9 = 1'b0;
    logic [3:0] bank_state;
    logic       illegal;
    logic [2:0] cmd_code;
    logic       auto_pre;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_state = 0;
    int m_cnt = 0;
    int m_rrd [2] = '{0, 0};

    sdram_cmd_monitor #(.BANKS(2), .TRC(TRC), .TRRD(TRRD)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .bank_sel(bank_sel), .addr9(addr9),
        .bank_state(bank_state), .illegal(illegal), .cmd_code(cmd_code),
        .auto_pre(auto_pre)
    );

    always #2.5 clk = ~clk;

    function automatic bit model_bad(input int cmd, input int bs);
        bit b;
        b = 0;
        case (m_state)
            0: begin
                if (cmd == 3 && m_rrd[1-bs] != 0) b = 1;
            end
            1: b = !(cmd == 6 || cmd == 7);
            default: b = (cmd != 7);
        endcase
        return b;
    endfunction

    task automatic check_out(input string tag, input bit e_ill, input int e_st,
                             input int e_cmd, input bit e_ap);
        logic [3:0] e_vec;
        e_vec = {2'(e_st), 2'(e_st)};
        checks++;
        if (illegal !== e_ill || bank_state !== e_vec ||
            cmd_code !== 3'(e_cmd) || auto_pre !== e_ap) begin
            errors++;
            $display("FAIL %s: ill=%0b st=%h cmd=%0d ap=%0b expected ill=%0b st=%h cmd=%0d ap=%0b",
                     tag, illegal, bank_state, cmd_code, auto_pre,
                     e_ill, e_vec, e_cmd, e_ap);
        end
    endtask

    // Drive one command at a falling edge, predict, and compare at the next
    task automatic step(input string tag, input bit cs, input int cmd,
                        input int bs, input bit a9);
        int  eff;
        bit  e_bad;
        bit  e_ap;
        cs_n = cs;
        {ras_n, cas_n, we_n} = 3'(cmd);
        bank_sel = 1'(bs);
        addr9 = a9;
        eff = cs ? 7 : cmd;
        e_bad = model_bad(eff, bs);
        e_ap = (eff == 4 || eff == 5) && a9;
        // timers advance
        for (int i = 0; i < 2; i++) if (m_rrd[i] != 0) m_rrd[i]--;
        if (m_state != 0) begin
            if (m_cnt <= 1) begin m_state = 0; m_cnt = 0; end
            else m_cnt--;
        end
        if (!e_bad) begin
            if (eff == 1) begin m_state = 1; m_cnt = TRC - 1; end
            if (eff == 0) begin m_state = 2; m_cnt = 1; end
            if (eff == 3) m_rrd[bs] = TRRD - 1;
        end
        @(negedge clk);
        check_out(tag, e_bad, m_state, eff, e_ap);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: expired, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int r;
        int cmd;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 reset state", 0, 0, 7, 0);

        // R2 deselected mode-set pattern reads as no-op
        step("R2 deselect", 1, 0, 0, 0);
        step("R2 precharge", 0, 2, 0, 0);
        step("R2 nop", 0, 7, 1, 0);
        // R10 auto-precharge marker
        step("R10 write ap", 0, 4, 0, 1);
        step("R10 read no ap", 0, 5, 1, 0);
        step("R10 activate addr9", 0, 3, 0, 1);
        step("R10 spacing gap", 0, 7, 0, 0);

        // R4 mode set, R7 burst stop flagged and exit after two cycles
        step("R4 mode set", 0, 0, 0, 0);
        step("R7 bstop in mode", 0, 6, 0, 0);
        step("R3 pulse ends", 0, 7, 0, 0);
        step("R4 mode set again", 0, 0, 1, 0);
        step("R7 nop in mode", 0, 7, 0, 0);

        // R4 refresh, R5/R8 rejections, R11 state kept, R6 exit timing
        step("R4 refresh", 0, 1, 0, 0);
        step("R8 precharge busy bank", 0, 2, 0, 0);
        step("R8 activate busy bank", 0, 3, 1, 0);
        step("R11 mode set in refresh", 0, 0, 0, 0);
        step("R5 bstop in refresh", 0, 6, 0, 0);
        step("R5 read in refresh", 0, 5, 1, 1);
        step("R6 last refresh cycle", 0, 7, 0, 0);
        step("R6 first idle cycle", 0, 2, 1, 0);

        // R9 activate spacing
        step("R9 act bank0", 0, 3, 0, 0);
        step("R9 act bank1 too soon", 0, 3, 1, 0);
        step("R9 act bank1 in time", 0, 3, 1, 0);
        step("R9 act bank0 too soon", 0, 3, 0, 0);
        step("R9 act bank0 same bank", 0, 7, 0, 0);
        step("R11 after flagged act", 0, 3, 0, 0);

        // Random traffic weighted towards no-op
        for (int n = 0; n < 3000; n++) begin
            r = int'($urandom_range(0, 99));
            if (r < 40) cmd = 7;
            else if (r < 44) cmd = 1;
            else if (r < 48) cmd = 0;
            else cmd = int'($urandom_range(0, 7));
            step("RANDOM", ($urandom_range(0, 9) == 0), cmd,
                 int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule